// File: doc/BRIEF.md
# Packet Dual-Cast Replicator

This block sits in a switch datapath between a single ingress packet stream and a set of egress ports. Each packet carries a header sideband on its first beat: a kind bit (read or write), a start address, the number of the port the packet entered on, and the number of the egress port it is routed to. Every packet goes to its routed egress port. Software can also mark one ingress port, one primary egress port, an inclusive address window and a secondary egress port. A write from the marked ingress port that is routed to the marked primary port, and whose start address lies in the window, is sent to both the primary port and the secondary port on the same beats.

The data path is combinational from ingress to egress. The routing decision is made on the first beat of a packet and held until its last beat. A duplicated beat is handed over only in a cycle where both target ports take it. A small register port holds the selections, the window, a global enable and one counter of duplicated packets per egress port.

Top module: `dc_replicator`

## Requirements
- R1: A packet that is not duplicated asserts only `eg_valid[in_dest]`, whatever the state of that port's ready. `eg_data` and `eg_last` equal `in_data` and `in_last` in the same cycle. `in_ready` follows the ready of the routed port.
- R2: A write (`in_kind`=1) is duplicated when its `in_src` equals the ingress select (register 1), its `in_dest` equals the primary select (register 2), and its `in_addr` lies in the window. The secondary select (register 3) names the second port.
- R3: The window is inclusive. Base (register 4) and limit (register 5) both qualify. Base-1 and limit+1 do not.
- R4: Reads (`in_kind`=0), packets from any other ingress port, and packets routed to any other egress port are never duplicated.
- R5: While a packet is duplicated, each of its two ports sees valid only when the other port is ready, and `in_ready` is the AND of the two readies. No beat is ever taken by one copy alone.
- R6: When the enable bit (register 0, bit 0) is clear, nothing is duplicated.
- R7: When the secondary select equals the primary select or the ingress select, the packet is sent once only.
- R8: The route and the duplicate decision are taken on the first beat of a packet. Sideband changes on later beats, and stalls, do not change them until the beat with `in_last` is accepted.
- R9: Register 8+p counts the duplicated packets sent to port p as secondary. It steps by one for each accepted duplicated first beat and reads zero after reset.
- R10: After reset every configuration register and counter reads 0, unused addresses read 0, and written configuration reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Ingress beat valid |
| in_ready | output | 1 | Ingress beat accepted |
| in_data | input | DW | Ingress beat data |
| in_last | input | 1 | Last beat of packet |
| in_kind | input | 1 | 1 = write, 0 = read (first beat) |
| in_src | input | PW | Ingress port number (first beat) |
| in_dest | input | PW | Routed egress port (first beat) |
| in_addr | input | AW | Start address (first beat) |
| eg_valid | output | NP | Per-port egress valid |
| eg_ready | input | NP | Per-port egress ready |
| eg_data | output | DW | Egress data shared by all ports |
| eg_last | output | 1 | Egress last shared by all ports |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |

## Verification
The assertions check these rules on every cycle: no egress handshake completes unless the ingress beat is accepted, an undecorated packet drives at most one valid, the route is held across the beats of a packet, reads and a cleared enable never duplicate, a duplicate never targets a port equal to the primary or ingress select, and the counters never jump. The bench scenarios cover the rest. They show that the window edges are inclusive, that each single disqualifying field stops the copy, which valid each port sees under each ready pattern, that the decision survives a mid-packet stall and changed sideband, and that the counters and registers hold the expected values.

// File: rtl/dc_pkg.sv
`timescale 1ns/1ps
package dc_pkg;
  localparam int CFG_AW = 4;
  localparam int CFG_DW = 32;

  localparam logic KIND_READ  = 1'b0;
  localparam logic KIND_WRITE = 1'b1;

  localparam logic [CFG_AW-1:0] REG_CTRL  = 4'd0;
  localparam logic [CFG_AW-1:0] REG_ING   = 4'd1;
  localparam logic [CFG_AW-1:0] REG_PRI   = 4'd2;
  localparam logic [CFG_AW-1:0] REG_SEC   = 4'd3;
  localparam logic [CFG_AW-1:0] REG_BASE  = 4'd4;
  localparam logic [CFG_AW-1:0] REG_LIMIT = 4'd5;
  localparam logic [CFG_AW-1:0] REG_CNT0  = 4'd8;
endpackage

// File: rtl/dc_cfg_regs.sv
`timescale 1ns/1ps
module dc_cfg_regs
  import dc_pkg::*;
#(
  parameter int NP = 4,
  parameter int AW = 32,
  parameter int CW = 16,
  localparam int PW = $clog2(NP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  output logic              en,
  output logic [PW-1:0]     ing_sel,
  output logic [PW-1:0]     pri_sel,
  output logic [PW-1:0]     sec_sel,
  output logic [AW-1:0]     win_base,
  output logic [AW-1:0]     win_limit,
  input  logic              inc_en,
  input  logic [PW-1:0]     inc_port
);
  logic          en_d;
  logic [PW-1:0] ing_d, pri_d, sec_d;
  logic [AW-1:0] base_d, limit_d;
  logic [CW-1:0] cnt_q [NP];

  always_comb begin
    en_d    = en;
    ing_d   = ing_sel;
    pri_d   = pri_sel;
    sec_d   = sec_sel;
    base_d  = win_base;
    limit_d = win_limit;
    if (cfg_we) begin
      case (cfg_addr)
        REG_CTRL:  en_d    = cfg_wdata[0];
        REG_ING:   ing_d   = cfg_wdata[PW-1:0];
        REG_PRI:   pri_d   = cfg_wdata[PW-1:0];
        REG_SEC:   sec_d   = cfg_wdata[PW-1:0];
        REG_BASE:  base_d  = cfg_wdata[AW-1:0];
        REG_LIMIT: limit_d = cfg_wdata[AW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= 1'b0;
      ing_sel   <= '0;
      pri_sel   <= '0;
      sec_sel   <= '0;
      win_base  <= '0;
      win_limit <= '0;
    end else begin
      en        <= en_d;
      ing_sel   <= ing_d;
      pri_sel   <= pri_d;
      sec_sel   <= sec_d;
      win_base  <= base_d;
      win_limit <= limit_d;
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_cnt
    logic          hit;
    logic [CW-1:0] cnt_d;

    always_comb begin
      hit   = inc_en && (inc_port == PW'(p));
      cnt_d = hit ? cnt_q[p] + 1'b1 : cnt_q[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q[p] <= '0;
      else        cnt_q[p] <= cnt_d;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[p] == $past(cnt_q[p])) || (cnt_q[p] == $past(cnt_q[p]) + 1'b1)); // R9
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      REG_CTRL:  cfg_rdata = CFG_DW'(en);
      REG_ING:   cfg_rdata = CFG_DW'(ing_sel);
      REG_PRI:   cfg_rdata = CFG_DW'(pri_sel);
      REG_SEC:   cfg_rdata = CFG_DW'(sec_sel);
      REG_BASE:  cfg_rdata = CFG_DW'(win_base);
      REG_LIMIT: cfg_rdata = CFG_DW'(win_limit);
      default: ;
    endcase
    for (int p = 0; p < NP; p++) begin
      if (cfg_addr == REG_CNT0 + CFG_AW'(p)) cfg_rdata = CFG_DW'(cnt_q[p]);
    end
  end
endmodule

// File: rtl/dc_qualify.sv
`timescale 1ns/1ps
module dc_qualify
  import dc_pkg::*;
#(
  parameter int NP = 4,
  parameter int AW = 32,
  localparam int PW = $clog2(NP)
) (
  input  logic          en,
  input  logic [PW-1:0] ing_sel,
  input  logic [PW-1:0] pri_sel,
  input  logic [PW-1:0] sec_sel,
  input  logic [AW-1:0] win_base,
  input  logic [AW-1:0] win_limit,
  input  logic          kind,
  input  logic [PW-1:0] src,
  input  logic [PW-1:0] dest,
  input  logic [AW-1:0] addr,
  output logic          dup
);
  logic in_win, from_sel, to_sel, sec_ok;

  always_comb begin
    in_win   = (addr >= win_base) && (addr <= win_limit);
    from_sel = (src == ing_sel);
    to_sel   = (dest == pri_sel);
    sec_ok   = (sec_sel != pri_sel) && (sec_sel != ing_sel);
    dup      = en && (kind == KIND_WRITE) && from_sel && to_sel && in_win && sec_ok;
  end
endmodule

// File: rtl/dc_fanout.sv
`timescale 1ns/1ps
module dc_fanout #(
  parameter int NP = 4,
  localparam int PW = $clog2(NP)
) (
  input  logic          in_valid,
  input  logic [PW-1:0] dest,
  input  logic [PW-1:0] sec,
  input  logic          dup,
  input  logic [NP-1:0] eg_ready,
  output logic [NP-1:0] eg_valid,
  output logic          in_ready
);
  logic [NP-1:0] tgt;

  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam logic [NP-1:0] SELF = NP'(1) << p;
    logic others_ok;

    always_comb begin
      tgt[p]      = (dest == PW'(p)) || (dup && (sec == PW'(p)));
      others_ok   = &(eg_ready | ~tgt | SELF);
      eg_valid[p] = in_valid && tgt[p] && others_ok;
    end
  end

  always_comb in_ready = &(eg_ready | ~tgt);
endmodule

// File: rtl/dc_replicator.sv
`timescale 1ns/1ps
module dc_replicator
  import dc_pkg::*;
#(
  parameter int NP = 4,
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int CW = 16,
  localparam int PW = $clog2(NP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  input  logic              in_last,
  input  logic              in_kind,
  input  logic [PW-1:0]     in_src,
  input  logic [PW-1:0]     in_dest,
  input  logic [AW-1:0]     in_addr,
  output logic [NP-1:0]     eg_valid,
  input  logic [NP-1:0]     eg_ready,
  output logic [DW-1:0]     eg_data,
  output logic              eg_last,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata
);
  logic          rst_meta_n, rst_q_n;
  logic          cfg_en;
  logic [PW-1:0] ing_sel, pri_sel, sec_sel;
  logic [AW-1:0] win_base, win_limit;
  logic          dup_now, fire, inc_en;
  logic          sop_q, sop_d;
  logic [PW-1:0] held_dest_q, held_dest_d, held_sec_q, held_sec_d;
  logic          held_dup_q, held_dup_d;
  logic [PW-1:0] route_dest, route_sec;
  logic          route_dup;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  dc_cfg_regs #(.NP(NP), .AW(AW), .CW(CW)) i_regs (
    .clk(clk), .rst_n(rst_q_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .en(cfg_en), .ing_sel(ing_sel), .pri_sel(pri_sel), .sec_sel(sec_sel),
    .win_base(win_base), .win_limit(win_limit),
    .inc_en(inc_en), .inc_port(sec_sel)
  );

  dc_qualify #(.NP(NP), .AW(AW)) i_qual (
    .en(cfg_en), .ing_sel(ing_sel), .pri_sel(pri_sel), .sec_sel(sec_sel),
    .win_base(win_base), .win_limit(win_limit),
    .kind(in_kind), .src(in_src), .dest(in_dest), .addr(in_addr),
    .dup(dup_now)
  );

  always_comb begin
    route_dest = sop_q ? in_dest : held_dest_q;
    route_sec  = sop_q ? sec_sel : held_sec_q;
    route_dup  = sop_q ? dup_now : held_dup_q;
  end

  dc_fanout #(.NP(NP)) i_fan (
    .in_valid(in_valid), .dest(route_dest), .sec(route_sec), .dup(route_dup),
    .eg_ready(eg_ready), .eg_valid(eg_valid), .in_ready(in_ready)
  );

  always_comb begin
    eg_data     = in_data;
    eg_last     = in_last;
    fire        = in_valid && in_ready;
    inc_en      = fire && sop_q && dup_now;
    sop_d       = fire ? in_last : sop_q;
    held_dest_d = (fire && sop_q) ? route_dest : held_dest_q;
    held_sec_d  = (fire && sop_q) ? route_sec  : held_sec_q;
    held_dup_d  = (fire && sop_q) ? route_dup  : held_dup_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sop_q       <= 1'b1;
      held_dest_q <= '0;
      held_sec_q  <= '0;
      held_dup_q  <= 1'b0;
    end else begin
      sop_q       <= sop_d;
      held_dest_q <= held_dest_d;
      held_sec_q  <= held_sec_d;
      held_dup_q  <= held_dup_d;
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_chk
    AST_NO_PARTIAL: assert property (@(posedge clk) disable iff (!rst_q_n)
      (eg_valid[p] && eg_ready[p]) |-> in_ready); // R5
  end

  AST_SINGLE_UNLESS_DUP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && !route_dup) |-> ($countones(eg_valid) <= 1)); // R1

  AST_DUP_DISTINCT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && sop_q && route_dup) |-> ((route_sec != pri_sel) && (route_sec != ing_sel))); // R7

  AST_ROUTE_HELD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fire && !in_last) |=> ((route_dest == $past(route_dest)) && (route_dup == $past(route_dup)))); // R8

  AST_NO_DUP_DISABLED: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && sop_q && !cfg_en) |-> !route_dup); // R6

  AST_READ_NOT_DUP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && sop_q && (in_kind == KIND_READ)) |-> !route_dup); // R4
endmodule

// File: tb/test_dc_replicator.sv
`timescale 1ns/1ps
module test_dc_replicator;
  localparam int NP = 4;
  localparam int AW = 32;
  localparam int DW = 64;

  typedef struct packed {
    logic        kind;
    logic [1:0]  src;
    logic [1:0]  dest;
    logic [31:0] addr;
    logic [3:0]  rdy;
    logic [3:0]  ev;
    logic        er;
    logic [3:0]  req;
  } vec_t;

  // config used by the table: enable, ingress 1, primary 2, secondary 3, window 0x1000..0x1FFF
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd1, 2'd2, 32'h0000_1000, 4'hF, 4'b1100, 1'b1, 4'd3},  // R3 base
    '{1'b1, 2'd1, 2'd2, 32'h0000_1FFF, 4'hF, 4'b1100, 1'b1, 4'd3},  // R3 limit
    '{1'b1, 2'd1, 2'd2, 32'h0000_0FFF, 4'hF, 4'b0100, 1'b1, 4'd3},  // R3 below
    '{1'b1, 2'd1, 2'd2, 32'h0000_2000, 4'hF, 4'b0100, 1'b1, 4'd3},  // R3 above
    '{1'b0, 2'd1, 2'd2, 32'h0000_1500, 4'hF, 4'b0100, 1'b1, 4'd4},  // R4 read
    '{1'b1, 2'd0, 2'd2, 32'h0000_1500, 4'hF, 4'b0100, 1'b1, 4'd4},  // R4 other src
    '{1'b1, 2'd1, 2'd0, 32'h0000_1500, 4'hF, 4'b0001, 1'b1, 4'd4},  // R4 other dest
    '{1'b1, 2'd1, 2'd2, 32'h0000_1500, 4'b0100, 4'b1000, 1'b0, 4'd5}, // R5 sec stalled
    '{1'b1, 2'd1, 2'd2, 32'h0000_1500, 4'b1000, 4'b0100, 1'b0, 4'd5}, // R5 pri stalled
    '{1'b1, 2'd1, 2'd2, 32'h0000_1500, 4'b1100, 4'b1100, 1'b1, 4'd2}, // R2 both ready
    '{1'b0, 2'd1, 2'd1, 32'h0000_0000, 4'b1101, 4'b0010, 1'b0, 4'd1}, // R1 dest stalled
    '{1'b1, 2'd1, 2'd3, 32'h0000_1500, 4'hF, 4'b1000, 1'b1, 4'd1}   // R1 plain route
  };

  logic            clk, rst_n;
  logic            in_valid, in_ready, in_last, in_kind;
  logic [DW-1:0]   in_data;
  logic [1:0]      in_src, in_dest;
  logic [AW-1:0]   in_addr;
  logic [NP-1:0]   eg_valid, eg_ready;
  logic [DW-1:0]   eg_data;
  logic            eg_last;
  logic            cfg_we;
  logic [3:0]      cfg_addr;
  logic [31:0]     cfg_wdata, cfg_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  dc_replicator #(.NP(NP), .AW(AW), .DW(DW), .CW(16)) i_dc_replicator (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .in_kind(in_kind), .in_src(in_src), .in_dest(in_dest), .in_addr(in_addr),
    .eg_valid(eg_valid), .eg_ready(eg_ready), .eg_data(eg_data), .eg_last(eg_last),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_check(input logic [3:0] a, input logic [31:0] exp_v, input string req);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(req, 64'(cfg_rdata), 64'(exp_v));
  endtask

  task automatic beat(input logic k, input logic [1:0] s, input logic [1:0] d,
                      input logic [31:0] a, input logic l, input logic [3:0] rdy,
                      input logic [3:0] ev, input logic er, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_src = s; in_dest = d; in_addr = a;
    in_last = l; eg_ready = rdy; in_data = {32'hC0DE_0000, a};
    #1;
    check(req, 64'(eg_valid), 64'(ev));
    check(req, 64'(in_ready), 64'(er));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; eg_ready = '1;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b1; in_kind = 1'b0;
    in_src = '0; in_dest = '0; in_addr = '0; in_data = '0;
    eg_ready = '1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state and readback
    #1;
    check("R10 idle valid", 64'(eg_valid), 64'd0);
    cfg_check(4'd0, 32'd0, "R10 ctrl");
    cfg_check(4'd5, 32'd0, "R10 limit");
    cfg_check(4'd11, 32'd0, "R9 counter reset");
    cfg_write(4'd0, 32'd1);
    cfg_write(4'd1, 32'd1);
    cfg_write(4'd2, 32'd2);
    cfg_write(4'd3, 32'd3);
    cfg_write(4'd4, 32'h1000);
    cfg_write(4'd5, 32'h1FFF);
    cfg_check(4'd4, 32'h1000, "R10 base readback");
    cfg_check(4'd3, 32'd3, "R10 sec readback");
    cfg_check(4'd6, 32'd0, "R10 unused addr");

    // R1 data passthrough
    @(negedge clk);
    in_valid = 1'b0; in_data = 64'hA5A5_0123_4567_89AB; in_last = 1'b1;
    #1;
    check("R1 data", eg_data, 64'hA5A5_0123_4567_89AB);
    check("R1 last", 64'(eg_last), 64'd1);

    foreach (VEC[i]) begin
      beat(VEC[i].kind, VEC[i].src, VEC[i].dest, VEC[i].addr, 1'b1, VEC[i].rdy,
           VEC[i].ev, VEC[i].er, $sformatf("R%0d vec%0d", VEC[i].req, i));
    end
    idle();
    cfg_check(4'd11, 32'd3, "R9 counter after table");

    // R6 enable cleared
    cfg_write(4'd0, 32'd0);
    beat(1'b1, 2'd1, 2'd2, 32'h1500, 1'b1, 4'hF, 4'b0100, 1'b1, "R6 disabled");
    idle();
    cfg_write(4'd0, 32'd1);

    // R7 secondary equals primary, then equals ingress
    cfg_write(4'd3, 32'd2);
    beat(1'b1, 2'd1, 2'd2, 32'h1500, 1'b1, 4'hF, 4'b0100, 1'b1, "R7 sec==pri");
    idle();
    cfg_write(4'd3, 32'd1);
    beat(1'b1, 2'd1, 2'd2, 32'h1500, 1'b1, 4'hF, 4'b0100, 1'b1, "R7 sec==ing");
    idle();
    cfg_write(4'd3, 32'd3);
    cfg_check(4'd11, 32'd3, "R9 counter unchanged");

    // R8 multi-beat duplicated packet with changed sideband and a stall
    beat(1'b1, 2'd1, 2'd2, 32'h1500, 1'b0, 4'hF,    4'b1100, 1'b1, "R8 beat0");
    beat(1'b0, 2'd0, 2'd0, 32'h0,    1'b0, 4'b0100, 4'b1000, 1'b0, "R8 stall");
    beat(1'b0, 2'd0, 2'd0, 32'h0,    1'b0, 4'hF,    4'b1100, 1'b1, "R8 beat1");
    beat(1'b0, 2'd0, 2'd0, 32'h0,    1'b1, 4'hF,    4'b1100, 1'b1, "R8 last");
    // R8 plain packet whose later beat looks qualifying
    beat(1'b0, 2'd1, 2'd2, 32'h1500, 1'b0, 4'hF,    4'b0100, 1'b1, "R8 plain0");
    beat(1'b1, 2'd1, 2'd2, 32'h1500, 1'b1, 4'hF,    4'b0100, 1'b1, "R8 plain1");
    idle();
    cfg_check(4'd11, 32'd4, "R9 counter final");
    cfg_check(4'd10, 32'd0, "R9 other port");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule